// File: doc/BRIEF.md
# ARINC 429 Triple-Register Bit Sampler

This block recovers data bits and word-gap nulls from a return-to-zero serial line. An external comparator stage classifies the differential line voltage into a 2-bit band code and presents it with a sample-clock enable. On each enabled cycle the block shifts the band into three parallel sampling registers, one for One, one for Zero and one for Null. Each register takes a 1 when the sample falls in its band and a 0 when it does not. At the nominal rate the enable comes from a 1 MHz timebase that is accurate to better than 0.1 %. That gives ten samples per high-speed bit period.

The block does not qualify a bit from one edge or from a midpoint sample. It applies window rules to the register contents instead. A data bit is accepted when the older half of the One or Zero register holds a run of consecutive hits and the newer half of the Null register also holds a run. A word-gap null is accepted when both halves of the Null register hold runs. Accepted bits are reported as a one-cycle strobe with the bit value. A separate one-cycle strobe marks the gap between words. A downstream word assembler consumes both strobes.

Top module: `a2s_bit_sampler`

## Requirements
- R1: The band code `line_code` is decoded as 2'b10 = One, 2'b01 = Zero, 2'b11 = Null and 2'b00 = between bands. A between-bands sample is a miss in all three registers, so it breaks any run. At most one register takes a hit per sample.
- R2: The sampling registers shift only on cycles where `sample_en` is high, and new samples enter at bit 0. Strobes appear only in the cycle right after an enabled cycle. Codes presented while `sample_en` is low have no effect.
- R3: `bit_valid` pulses for one cycle, in the cycle after the deciding sample, when both of the following hold: the upper half (bits SAMPLE_W-1..SAMPLE_W/2, the older samples) of the One or Zero register holds at least RUN_LEN consecutive hits, and the lower half of the Null register holds at least RUN_LEN consecutive hits. `bit_value` is 1 for a One and 0 for a Zero. A high phase of only two samples never qualifies, and a high phase of three samples does.
- R4: After a bit strobe, no further bit strobe is issued until the block has taken a non-Null sample for which neither bit condition holds. Each transmitted bit therefore yields exactly one strobe.
- R5: `gap_strobe` pulses for one cycle when both halves of the Null register hold at least RUN_LEN consecutive hits. It never coincides with `bit_valid`.
- R6: The gap strobe fires once when the gap condition first holds, and it does not fire again until a bit strobe has been issued. After reset it is armed.
- R7: No strobe is issued until SAMPLE_W samples have been taken since reset. With an all-Null line, the gap strobe follows the SAMPLE_W-th sample and not an earlier one.
- R8: Driving `rst_n` low asynchronously clears the registers and drives both strobes low. Release is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample-clock enable, one cycle per line sample |
| line_code | input | 2 | Band code from the comparator stage |
| bit_valid | output | 1 | One-cycle strobe for an accepted data bit |
| bit_value | output | 1 | Value of the accepted bit, 1 = One |
| gap_strobe | output | 1 | One-cycle strobe for an accepted word-gap null |

## Verification
The bench builds the block with its defaults: SAMPLE_W = 10 and RUN_LEN = 3. With these values the run-of-three boundary can be reached by high phases of two and three samples, and the fill limit by a nine- versus ten-sample null lead-in. Random bit trains vary the high and null phase lengths between two and seven samples and scatter between-bands noise and disabled cycles through them. This exercises the rearm rules across jittered streams, not only nominal five-and-five bits.

// File: rtl/a2s_pkg.sv
package a2s_pkg;

  typedef enum logic [1:0] {
    LC_BETWEEN = 2'b00,
    LC_ZERO    = 2'b01,
    LC_ONE     = 2'b10,
    LC_NULL    = 2'b11
  } line_code_e;

  localparam int unsigned BAND_CNT = 3;
  localparam int unsigned ST_ONE   = 0;
  localparam int unsigned ST_ZERO  = 1;
  localparam int unsigned ST_NULL  = 2;

endpackage

// File: rtl/a2s_rst_sync.sv
module a2s_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/a2s_band_decode.sv
module a2s_band_decode
  import a2s_pkg::*;
(
  input  logic [1:0]          code,
  output logic [BAND_CNT-1:0] hot
);

  always_comb begin
    hot = '0;
    case (line_code_e'(code))
      LC_ONE:  hot[ST_ONE]  = 1'b1;
      LC_ZERO: hot[ST_ZERO] = 1'b1;
      LC_NULL: hot[ST_NULL] = 1'b1;
      default: hot = '0;
    endcase
  end

endmodule

// File: rtl/a2s_sample_shreg.sv
module a2s_sample_shreg #(
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned OUT_LSB = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   din,
  output logic [DEPTH-1:OUT_LSB] tap
);

  logic [DEPTH-1:0] vec_q;
  logic [DEPTH-1:0] vec_d;

  always_comb begin
    vec_d = vec_q;
    if (shift_en) begin
      vec_d = {vec_q[DEPTH-2:0], din};
    end
  end

  assign tap = vec_d[DEPTH-1:OUT_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else begin
      vec_q <= vec_d;
    end
  end

endmodule

// File: rtl/a2s_run_detect.sv
module a2s_run_detect #(
  parameter int unsigned LEN = 5,
  parameter int unsigned RUN = 3
) (
  input  logic [LEN-1:0] vec,
  output logic           found
);

  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] run_cnt;

  always_comb begin
    run_cnt = '0;
    found   = 1'b0;
    for (int i = 0; i < LEN; i++) begin
      if (vec[i]) begin
        run_cnt = run_cnt + CW'(1);
      end else begin
        run_cnt = '0;
      end
      if (run_cnt >= CW'(RUN)) begin
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/a2s_strobe_ctrl.sv
module a2s_strobe_ctrl #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic nonnull_smp,
  input  logic hi_one,
  input  logic hi_zero,
  input  logic hi_null,
  input  logic lo_null,
  output logic bit_valid,
  output logic bit_value,
  output logic gap_strobe
);

  localparam int unsigned FW = $clog2(SAMPLE_W + 1);
  localparam logic [FW-1:0] FILL_TOP  = FW'(SAMPLE_W);
  localparam logic [FW-1:0] FILL_LAST = FW'(SAMPLE_W - 1);

  logic [FW-1:0] fill_q, fill_d;
  logic bit_arm_q, bit_arm_d;
  logic gap_arm_q, gap_arm_d;
  logic bv_q, bv_d;
  logic val_q, val_d;
  logic gap_q, gap_d;

  logic filled_now;
  logic one_ok, zero_ok, gap_ok, any_bit;
  logic bit_hit, gap_hit;

  always_comb begin
    one_ok     = hi_one  & lo_null;
    zero_ok    = hi_zero & lo_null;
    gap_ok     = hi_null & lo_null;
    any_bit    = one_ok | zero_ok;
    filled_now = (fill_q >= FILL_LAST);

    bit_hit = sample_en & filled_now & bit_arm_q & any_bit;
    gap_hit = sample_en & filled_now & gap_arm_q & gap_ok;

    fill_d = fill_q;
    if (sample_en && (fill_q != FILL_TOP)) begin
      fill_d = fill_q + FW'(1);
    end

    bit_arm_d = bit_arm_q;
    if (bit_hit) begin
      bit_arm_d = 1'b0;
    end else if (sample_en && nonnull_smp && !any_bit) begin
      bit_arm_d = 1'b1;
    end

    gap_arm_d = gap_arm_q;
    if (gap_hit) begin
      gap_arm_d = 1'b0;
    end else if (bit_hit) begin
      gap_arm_d = 1'b1;
    end

    bv_d  = bit_hit;
    val_d = bit_hit & one_ok;
    gap_d = gap_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      bit_arm_q <= 1'b1;
      gap_arm_q <= 1'b1;
      bv_q      <= 1'b0;
      val_q     <= 1'b0;
      gap_q     <= 1'b0;
    end else begin
      fill_q    <= fill_d;
      bit_arm_q <= bit_arm_d;
      gap_arm_q <= gap_arm_d;
      bv_q      <= bv_d;
      val_q     <= val_d;
      gap_q     <= gap_d;
    end
  end

  assign bit_valid  = bv_q;
  assign bit_value  = val_q;
  assign gap_strobe = gap_q;

endmodule

// File: rtl/a2s_bit_sampler.sv
module a2s_bit_sampler
  import a2s_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned RUN_LEN  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic [1:0] line_code,
  output logic       bit_valid,
  output logic       bit_value,
  output logic       gap_strobe
);

  localparam int unsigned HALF_W = SAMPLE_W / 2;
  localparam int unsigned HI_W   = SAMPLE_W - HALF_W;

  logic                rst_core_n;
  logic [BAND_CNT-1:0] smp_hot;
  logic [HI_W-1:0]     hi_tap [BAND_CNT];
  logic [BAND_CNT-1:0] hi_run;
  logic [HALF_W-1:0]   lo_null_tap;
  logic                lo_null_run;

  a2s_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  a2s_band_decode u_decode (
    .code (line_code),
    .hot  (smp_hot)
  );

  // One sampling register per band; only the Null register exposes its lower half.
  for (genvar g = 0; g < BAND_CNT; g++) begin : g_band
    localparam int unsigned OFS = (g == ST_NULL) ? 0 : HALF_W;
    logic [SAMPLE_W-1:OFS] tap;

    a2s_sample_shreg #(
      .DEPTH   (SAMPLE_W),
      .OUT_LSB (OFS)
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .shift_en (sample_en),
      .din      (smp_hot[g]),
      .tap      (tap)
    );

    assign hi_tap[g] = tap[SAMPLE_W-1:HALF_W];

    a2s_run_detect #(
      .LEN (HI_W),
      .RUN (RUN_LEN)
    ) u_hi_run (
      .vec   (hi_tap[g]),
      .found (hi_run[g])
    );

    if (g == ST_NULL) begin : g_lo
      assign lo_null_tap = tap[HALF_W-1:0];
    end
  end

  a2s_run_detect #(
    .LEN (HALF_W),
    .RUN (RUN_LEN)
  ) u_lo_run (
    .vec   (lo_null_tap),
    .found (lo_null_run)
  );

  a2s_strobe_ctrl #(
    .SAMPLE_W (SAMPLE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sample_en   (sample_en),
    .nonnull_smp (~smp_hot[ST_NULL]),
    .hi_one      (hi_run[ST_ONE]),
    .hi_zero     (hi_run[ST_ZERO]),
    .hi_null     (hi_run[ST_NULL]),
    .lo_null     (lo_null_run),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .gap_strobe  (gap_strobe)
  );

endmodule

// File: rtl/a2s_bit_sampler_chk.sv
module a2s_bit_sampler_chk #(
  parameter int unsigned SAMPLE_W = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_en,
  input logic [2:0] smp_hot,
  input logic       bit_valid,
  input logic       gap_strobe
);

  localparam int unsigned CW = $clog2(SAMPLE_W + 1);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (sample_en && (seen_q != CW'(SAMPLE_W))) begin
      seen_q <= seen_q + CW'(1);
    end
  end

  assert_onehot_band_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(smp_hot));

  assert_bit_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sample_en));

  assert_gap_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_strobe |-> $past(sample_en));

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && gap_strobe));

  assert_single_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_strobe |=> !gap_strobe);

  assert_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid || gap_strobe) |-> (seen_q == CW'(SAMPLE_W)));

endmodule

bind a2s_bit_sampler a2s_bit_sampler_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_en  (sample_en),
  .smp_hot    (smp_hot),
  .bit_valid  (bit_valid),
  .gap_strobe (gap_strobe)
);

// File: tb/a2s_bit_sampler_test.sv
`timescale 1ns/1ps
module a2s_bit_sampler_test;

  localparam logic [1:0] C_BTW  = 2'b00;
  localparam logic [1:0] C_ZERO = 2'b01;
  localparam logic [1:0] C_ONE  = 2'b10;
  localparam logic [1:0] C_NULL = 2'b11;

  logic       clk;
  logic       rst_n;
  logic       sample_en;
  logic [1:0] line_code;
  logic       bit_valid;
  logic       bit_value;
  logic       gap_strobe;

  int total;
  int bad;
  bit done;

  // reference state, written from the requirements
  logic [9:0] m_one, m_zero, m_null;
  int  m_fill;
  bit  m_barm, m_garm;
  bit  e_bv, e_val, e_gap;

  int          obs_bits;
  int          obs_gaps;
  logic [31:0] obs_vals;

  a2s_bit_sampler uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .line_code  (line_code),
    .bit_valid  (bit_valid),
    .bit_value  (bit_value),
    .gap_strobe (gap_strobe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit run3(input logic [4:0] v);
    return (v[0] & v[1] & v[2]) | (v[1] & v[2] & v[3]) | (v[2] & v[3] & v[4]);
  endfunction

  task automatic model_reset();
    m_one = '0; m_zero = '0; m_null = '0;
    m_fill = 0; m_barm = 1'b1; m_garm = 1'b1;
    e_bv = 1'b0; e_val = 1'b0; e_gap = 1'b0;
  endtask

  task automatic model_sample(input logic [1:0] c);
    bit full, c1, c0, cg, bh, gh, nul;
    nul    = (c == C_NULL);
    m_one  = {m_one[8:0],  c == C_ONE};
    m_zero = {m_zero[8:0], c == C_ZERO};
    m_null = {m_null[8:0], nul};
    full = (m_fill >= 9);
    if (m_fill < 10) m_fill++;
    c1 = run3(m_one[9:5])  && run3(m_null[4:0]);
    c0 = run3(m_zero[9:5]) && run3(m_null[4:0]);
    cg = run3(m_null[9:5]) && run3(m_null[4:0]);
    bh = full && m_barm && (c1 || c0);
    gh = full && m_garm && cg;
    e_bv = bh; e_val = bh && c1; e_gap = gh;
    if (bh) m_barm = 1'b0;
    else if (!nul && !(c1 || c0)) m_barm = 1'b1;
    if (gh) m_garm = 1'b0;
    else if (bh) m_garm = 1'b1;
  endtask

  task automatic compare_outputs();
    total++;
    if (bit_valid !== e_bv || (e_bv && bit_value !== e_val)) begin
      bad++;
      $display("FAIL R3 bit strobe/value: actual=%b/%b expected=%b/%b t=%0t",
               bit_valid, bit_value, e_bv, e_val, $time);
    end
    total++;
    if (gap_strobe !== e_gap) begin
      bad++;
      $display("FAIL R5 gap strobe: actual=%b expected=%b t=%0t", gap_strobe, e_gap, $time);
    end
    if (bit_valid === 1'b1) begin
      obs_bits++;
      obs_vals = {obs_vals[30:0], bit_value};
    end
    if (gap_strobe === 1'b1) obs_gaps++;
  endtask

  task automatic step(input bit en, input logic [1:0] c);
    @(negedge clk);
    compare_outputs();
    sample_en = en;
    line_code = c;
    if (en) model_sample(c);
    else begin e_bv = 1'b0; e_val = 1'b0; e_gap = 1'b0; end
  endtask

  task automatic send_bit(input bit v, input int hi_len, input int lo_len);
    for (int i = 0; i < hi_len; i++) step(1'b1, v ? C_ONE : C_ZERO);
    for (int i = 0; i < lo_len; i++) step(1'b1, C_NULL);
  endtask

  task automatic nulls(input int n);
    for (int i = 0; i < n; i++) step(1'b1, C_NULL);
  endtask

  task automatic flush();
    step(1'b0, C_BTW);
    step(1'b0, C_BTW);
  endtask

  task automatic expect_int(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_en = 1'b0;
    line_code = C_BTW;
    #1;
    total++;
    if (bit_valid !== 1'b0 || gap_strobe !== 1'b0) begin
      bad++;
      $display("FAIL R8 outputs in reset: actual=%b%b expected=00", bit_valid, gap_strobe);
    end
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, C_BTW);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b0, g0;
    logic [7:0] word;
    total = 0; bad = 0; done = 1'b0;
    obs_bits = 0; obs_gaps = 0; obs_vals = '0;
    rst_n = 1'b0; sample_en = 1'b0; line_code = C_BTW;
    void'($urandom(32'd429));
    model_reset();
    do_reset();

    // R7: all-Null lead-in, gap only after the tenth sample
    g0 = obs_gaps;
    nulls(9); flush();
    expect_int(obs_gaps - g0, 0, "R7", "gaps after nine samples");
    nulls(1); flush();
    expect_int(obs_gaps - g0, 1, "R7", "gaps after ten samples");

    // R3 R4: an eight-bit word gives exactly eight strobes with matching values
    word = 8'b1011_0010;
    b0 = obs_bits;
    for (int i = 7; i >= 0; i--) send_bit(word[i], 5, 5);
    flush();
    expect_int(obs_bits - b0, 8, "R4", "strobes per word");
    expect_int(int'(obs_vals[7:0]), int'(word), "R3", "bit values");

    // R5 R6: one gap strobe after the word, none for a longer gap
    g0 = obs_gaps;
    nulls(15); flush();
    expect_int(obs_gaps - g0, 1, "R6", "gap strobes after word");
    nulls(15); flush();
    expect_int(obs_gaps - g0, 1, "R6", "no second gap without a bit");

    // R1: a between-bands sample splits the run, so no bit is accepted
    b0 = obs_bits;
    step(1'b1, C_ONE); step(1'b1, C_ONE); step(1'b1, C_BTW);
    step(1'b1, C_ONE); step(1'b1, C_ONE);
    nulls(5);
    for (int i = 0; i < 10; i++) step(1'b1, C_BTW);
    flush();
    expect_int(obs_bits - b0, 0, "R1", "split run bits");
    send_bit(1'b0, 5, 5); flush();
    expect_int(obs_bits - b0, 1, "R1", "zero code accepted");
    expect_int(int'(obs_vals[0]), 0, "R1", "zero code value");

    // R2: codes presented without enable are ignored
    b0 = obs_bits;
    for (int i = 0; i < 20; i++) step(1'b0, C_ONE);
    flush();
    expect_int(obs_bits - b0, 0, "R2", "bits while disabled");
    send_bit(1'b1, 5, 5); flush();
    expect_int(obs_bits - b0, 1, "R2", "bit after idle");
    expect_int(int'(obs_vals[0]), 1, "R2", "value after idle");

    // R3 boundary: two high samples rejected, three accepted
    b0 = obs_bits;
    send_bit(1'b1, 2, 8); flush();
    expect_int(obs_bits - b0, 0, "R3", "two-sample high phase");
    send_bit(1'b1, 3, 7); flush();
    expect_int(obs_bits - b0, 1, "R3", "three-sample high phase");

    // random trains with jitter, noise and idle cycles
    for (int n = 0; n < 400; n++) begin
      int hl, ll;
      hl = $urandom_range(2, 7);
      ll = $urandom_range(2, 7);
      for (int i = 0; i < hl; i++) begin
        if ($urandom_range(0, 15) == 0) step(1'b0, 2'($urandom_range(0, 3)));
        if ($urandom_range(0, 20) == 0) step(1'b1, C_BTW);
        else step(1'b1, $urandom_range(0, 1) ? C_ONE : C_ZERO);
      end
      nulls(ll);
      if ($urandom_range(0, 9) == 0) nulls($urandom_range(10, 40));
    end
    flush();

    // R8 R7: reset mid-stream restarts the fill count
    send_bit(1'b1, 5, 3);
    do_reset();
    g0 = obs_gaps;
    nulls(9); flush();
    expect_int(obs_gaps - g0, 0, "R8", "gaps before refill");
    nulls(1); flush();
    expect_int(obs_gaps - g0, 1, "R7", "gap after refill");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule